// File: doc/BRIEF.md
# Remote Terminal Host Register and Address-Parity Unit

This block is the host-facing register pair of a serial-bus remote terminal. A host processor reaches it through chip-select, register-select, read/write and output-enable lines and a 16-bit data path. A write stores the terminal's control settings: channel enables, status-word flag requests, broadcast acceptance, self-test controls and the lead time of the RAM-busy warning. A read returns a live 16-bit status image built from those settings and from events that the protocol engine reports. When register-select is high, the access is flagged for the message RAM instead, and this block does not decode it.

While master reset is held, the block samples the 5-bit terminal address and its parity pin. Across the six bits the parity must be odd. If the check fails, both bus channels are forced off, the parity-error status bit is set, and the message-error pin and latch are raised. The unit also keeps the message-error pin and status latch, which clear under different rules. It tracks the terminal-flag inhibit mode, compares an incoming command address against the terminal's own address and the broadcast address, and freezes an outgoing status word on each rising edge of the command strobe.

Top module: `rt_host_regs`

## Requirements
- R1: After reset with a correctly odd address parity, the status image reads 0x07C0, both channel enables are 1 and the RAM-busy long-lead select is 1.
- R2: The data bus is driven (`dataOe`=1) only when `csN`=0, `regSelN`=0, `rdWrN`=1 and `oeN`=0. With `oeN`=1 it is released. With `csN`=0 and `regSelN`=1 the access is flagged on `ramSel` and the bus is not driven.
- R3: A control write (`csN`=0, `regSelN`=0, `rdWrN`=0) stores data bits 12:0 with this layout: bit0 channel A enable, 1 channel B enable, 2 terminal flag, 3 system busy, 4 subsystem busy, 5 self-test channel A select, 6 self-test enable, 7 service request, 8 instrumentation, 9 broadcast enable, 12 RAM-busy long lead. Data bits 10 and 11 have no effect.
- R4: The terminal address and parity are sampled only while `rstN` is low. Later changes on those pins have no effect.
- R5: If the six sampled bits have even parity, status bit 12 is set, `chanEn` stays 00 whatever the control register holds, and `msgErrPin` is raised.
- R6: `msgErrEvt` raises `msgErrPin` on the next edge. `cmdValid` clears it on the next edge, unless `msgErrEvt` arrives in the same cycle, in which case setting wins.
- R7: Status bit 13 is set by `msgErrEvt`. It clears only on the clock edge that ends a status read taken while `errCond` is 0. A coincident `msgErrEvt` wins over that clear.
- R8: `bcastHit` is 1 only when broadcast is enabled and `cmdAddr`=11111. `addrHit` is 1 on an own-address match or a broadcast hit, so with broadcast disabled 11111 is an ordinary address.
- R9: `modeInhibitTf` clears status bit 9 and forces the outgoing terminal flag to 0 until `modeOverrideTf` arrives.
- R10: `statusWord` changes only on the edge where `cmdStrobeN` is first seen high after being low. It then holds address in 15:11, message-error pin 10, instrumentation 9, service request 8, broadcast received 4, busy 3, subsystem busy 2, terminal flag 0, and zeros elsewhere.
- R11: On `cmdValid`, status bits 4:0 take `cmdField`, bit 5 is the inverse of `cmdIsMode`, bit 6 takes `cmdChanA`, and bit 14 clears. `validMsgEvt` sets bit 14. Bit 15 follows `termActive`. Bits 7/8 show channel B/A enabled, 10 busy, 11 self-test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Master reset, active low, synchronous |
| csN | input | 1 | Chip select, active low |
| regSelN | input | 1 | Register select, low = registers, high = RAM |
| rdWrN | input | 1 | 1 = read, 0 = write |
| oeN | input | 1 | Output enable, active low |
| dataIn | input | 16 | Host write data |
| dataOut | output | 16 | Status image (bus value when driven) |
| dataOe | output | 1 | Bus drive enable |
| ramSel | output | 1 | Access is routed to RAM |
| termAddr | input | 5 | Terminal address pins |
| termPar | input | 1 | Terminal address parity pin |
| cmdValid | input | 1 | Valid command pulse |
| cmdAddr | input | 5 | Address field of incoming command |
| cmdField | input | 5 | Subaddress or mode code of command |
| cmdIsMode | input | 1 | Command is a mode command |
| cmdChanA | input | 1 | Command arrived on channel A |
| cmdStrobeN | input | 1 | Command strobe, active low |
| msgErrEvt | input | 1 | Message error event pulse |
| errCond | input | 1 | Error condition still present |
| validMsgEvt | input | 1 | Valid message pulse |
| termActive | input | 1 | Terminal active level |
| modeInhibitTf | input | 1 | Inhibit terminal flag mode pulse |
| modeOverrideTf | input | 1 | Override inhibit mode pulse |
| chanEn | output | 2 | Channel enables, bit0 A, bit1 B |
| selfTestEn | output | 1 | Self-test mode |
| selfTestSelA | output | 1 | Self-test on channel A |
| rbusyLong | output | 1 | RAM-busy long lead select |
| addrHit | output | 1 | Command addressed to this terminal |
| bcastHit | output | 1 | Command is an accepted broadcast |
| msgErrPin | output | 1 | Message error pin |
| statusWord | output | 16 | Frozen outgoing status word |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a message-error event and a status read that would clear the error latch. The second is a message-error event and the valid command that would drop the error pin. The bench drives each pair together in one cycle. It then judges the latch and the pin at the ports after that edge, where setting must win. It repeats each clear on its own to show that the clear path works.

// File: rtl/rt_host_pkg.sv
package rt_host_pkg;
  // control register bit positions (layout is host-visible)
  localparam int CB_CHA   = 0;
  localparam int CB_CHB   = 1;
  localparam int CB_TF    = 2;
  localparam int CB_BUSY  = 3;
  localparam int CB_SUBS  = 4;
  localparam int CB_STSEL = 5;
  localparam int CB_STEN  = 6;
  localparam int CB_SRQ   = 7;
  localparam int CB_INSTR = 8;
  localparam int CB_BCEN  = 9;
  localparam int CB_RBL   = 12;
  localparam int CTRL_W   = 13;
  localparam logic [CTRL_W-1:0] CTRL_RST  = 13'h120B;
  localparam logic [CTRL_W-1:0] CTRL_MASK = 13'h13FF;

  typedef struct packed {
    logic ctrlWr;
    logic stsRd;
    logic strobeRise;
  } hostStrobe_t;
endpackage

// File: rtl/rt_host_decode.sv
module rt_host_decode
  import rt_host_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        regSelN,
  input  logic        rdWrN,
  input  logic        oeN,
  input  logic        cmdStrobeN,
  output hostStrobe_t strb,
  output logic        dataOe,
  output logic        ramSel
);
  logic strobePrev;
  logic regAccess;

  always_ff @(posedge clk) begin
    if (!rstN) strobePrev <= 1'b1;
    else       strobePrev <= cmdStrobeN;
  end

  always_comb begin
    regAccess       = !csN && !regSelN;
    strb.stsRd      = regAccess && rdWrN && !oeN;
    strb.ctrlWr     = regAccess && !rdWrN;
    strb.strobeRise = cmdStrobeN && !strobePrev;
    dataOe          = strb.stsRd;
    ramSel          = !csN && regSelN;
  end
endmodule

// File: rtl/rt_host_dp.sv
module rt_host_dp
  import rt_host_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int BUS_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  hostStrobe_t       strb,
  input  logic [BUS_W-1:0]  dataIn,
  input  logic [ADDR_W-1:0] termAddr,
  input  logic              termPar,
  input  logic              cmdValid,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [4:0]        cmdField,
  input  logic              cmdIsMode,
  input  logic              cmdChanA,
  input  logic              msgErrEvt,
  input  logic              errCond,
  input  logic              validMsgEvt,
  input  logic              termActive,
  input  logic              modeInhibitTf,
  input  logic              modeOverrideTf,
  output logic [BUS_W-1:0]  statusImg,
  output logic [1:0]        chanEn,
  output logic              selfTestEn,
  output logic              selfTestSelA,
  output logic              rbusyLong,
  output logic              addrHit,
  output logic              bcastHit,
  output logic              msgErrPin,
  output logic [BUS_W-1:0]  statusWord
);
  localparam int FLAG_GAP = BUS_W - ADDR_W - 8;

  logic [CTRL_W-1:0] ctrlQ;
  logic [ADDR_W-1:0] addrQ;
  logic              parErr, msgErrSts, tfEn, isSaQ, lastChA;
  logic              validMsgQ, bcastRcvQ;
  logic [4:0]        fieldQ;
  logic              resetParBad;
  logic              tfOut;
  logic [BUS_W-1:0]  wordNext;
  logic              unusedBits;

  assign resetParBad = ~^{termAddr, termPar};
  assign unusedBits  = ^{dataIn[BUS_W-1:CTRL_W], ctrlQ[11:10]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ      <= CTRL_RST;
      addrQ      <= termAddr;
      parErr     <= resetParBad;
      msgErrSts  <= resetParBad;
      msgErrPin  <= resetParBad;
      tfEn       <= 1'b1;
      fieldQ     <= '0;
      isSaQ      <= 1'b0;
      lastChA    <= 1'b1;
      validMsgQ  <= 1'b0;
      bcastRcvQ  <= 1'b0;
      statusWord <= '0;
    end else begin
      if (strb.ctrlWr) ctrlQ <= dataIn[CTRL_W-1:0] & CTRL_MASK;

      if (msgErrEvt)                         msgErrSts <= 1'b1;
      else if (strb.stsRd && !errCond)       msgErrSts <= 1'b0;

      if (msgErrEvt)     msgErrPin <= 1'b1;
      else if (cmdValid) msgErrPin <= 1'b0;

      if (modeInhibitTf)       tfEn <= 1'b0;
      else if (modeOverrideTf) tfEn <= 1'b1;

      if (cmdValid) begin
        fieldQ    <= cmdField;
        isSaQ     <= !cmdIsMode;
        lastChA   <= cmdChanA;
        bcastRcvQ <= bcastHit;
      end

      if (validMsgEvt)   validMsgQ <= 1'b1;
      else if (cmdValid) validMsgQ <= 1'b0;

      if (strb.strobeRise) statusWord <= wordNext;
    end
  end

  always_comb begin
    chanEn[0]    = ctrlQ[CB_CHA] && !parErr;
    chanEn[1]    = ctrlQ[CB_CHB] && !parErr;
    selfTestEn   = ctrlQ[CB_STEN];
    selfTestSelA = ctrlQ[CB_STSEL];
    rbusyLong    = ctrlQ[CB_RBL];
    bcastHit     = ctrlQ[CB_BCEN] && (cmdAddr == '1);
    addrHit      = (cmdAddr == addrQ) || bcastHit;
    tfOut        = ctrlQ[CB_TF] && tfEn;

    statusImg = {termActive, validMsgQ, msgErrSts, parErr,
                 ctrlQ[CB_STEN], ctrlQ[CB_BUSY], tfEn,
                 chanEn[0], chanEn[1], lastChA, isSaQ, fieldQ};

    wordNext = {addrQ, msgErrPin, ctrlQ[CB_INSTR], ctrlQ[CB_SRQ],
                {FLAG_GAP{1'b0}}, bcastRcvQ, ctrlQ[CB_BUSY],
                ctrlQ[CB_SUBS], 1'b0, tfOut};
  end
endmodule

// File: rtl/rt_host_regs.sv
module rt_host_regs
  import rt_host_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int BUS_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              regSelN,
  input  logic              rdWrN,
  input  logic              oeN,
  input  logic [BUS_W-1:0]  dataIn,
  output logic [BUS_W-1:0]  dataOut,
  output logic              dataOe,
  output logic              ramSel,
  input  logic [ADDR_W-1:0] termAddr,
  input  logic              termPar,
  input  logic              cmdValid,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [4:0]        cmdField,
  input  logic              cmdIsMode,
  input  logic              cmdChanA,
  input  logic              cmdStrobeN,
  input  logic              msgErrEvt,
  input  logic              errCond,
  input  logic              validMsgEvt,
  input  logic              termActive,
  input  logic              modeInhibitTf,
  input  logic              modeOverrideTf,
  output logic [1:0]        chanEn,
  output logic              selfTestEn,
  output logic              selfTestSelA,
  output logic              rbusyLong,
  output logic              addrHit,
  output logic              bcastHit,
  output logic              msgErrPin,
  output logic [BUS_W-1:0]  statusWord
);
  hostStrobe_t strb;

  rt_host_decode u_dec (
    .clk(clk), .rstN(rstN), .csN(csN), .regSelN(regSelN), .rdWrN(rdWrN),
    .oeN(oeN), .cmdStrobeN(cmdStrobeN), .strb(strb), .dataOe(dataOe),
    .ramSel(ramSel)
  );

  rt_host_dp #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .dataIn(dataIn),
    .termAddr(termAddr), .termPar(termPar), .cmdValid(cmdValid),
    .cmdAddr(cmdAddr), .cmdField(cmdField), .cmdIsMode(cmdIsMode),
    .cmdChanA(cmdChanA), .msgErrEvt(msgErrEvt), .errCond(errCond),
    .validMsgEvt(validMsgEvt), .termActive(termActive),
    .modeInhibitTf(modeInhibitTf), .modeOverrideTf(modeOverrideTf),
    .statusImg(dataOut), .chanEn(chanEn), .selfTestEn(selfTestEn),
    .selfTestSelA(selfTestSelA), .rbusyLong(rbusyLong), .addrHit(addrHit),
    .bcastHit(bcastHit), .msgErrPin(msgErrPin), .statusWord(statusWord)
  );
endmodule

// File: rtl/rt_host_regs_chk.sv
module rt_host_regs_chk #(
  parameter int BUS_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             csN,
  input logic             regSelN,
  input logic             rdWrN,
  input logic             oeN,
  input logic             errCond,
  input logic             msgErrEvt,
  input logic             cmdValid,
  input logic             cmdStrobeN,
  input logic [BUS_W-1:0] dataOut,
  input logic             dataOe,
  input logic [1:0]       chanEn,
  input logic             msgErrPin,
  input logic [BUS_W-1:0] statusWord
);
  logic prevStrobe;
  logic hostRead;

  always_ff @(posedge clk) begin
    if (!rstN) prevStrobe <= 1'b1;
    else       prevStrobe <= cmdStrobeN;
  end

  assign hostRead = !csN && !regSelN && rdWrN && !oeN;

  a_r2_released: assert property (@(posedge clk) disable iff (!rstN)
    oeN |-> !dataOe);

  a_r5_chan_off: assert property (@(posedge clk) disable iff (!rstN)
    dataOut[12] |-> (chanEn == 2'b00));

  a_r6_pin_set: assert property (@(posedge clk) disable iff (!rstN)
    msgErrEvt |=> msgErrPin);

  a_r6_pin_clear: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !msgErrEvt) |=> !msgErrPin);

  a_r7_latch_hold: assert property (@(posedge clk) disable iff (!rstN)
    (dataOut[13] && !(hostRead && !errCond)) |=> dataOut[13]);

  a_r10_word_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdStrobeN && !prevStrobe) |=> $stable(statusWord));
endmodule

bind rt_host_regs rt_host_regs_chk #(.BUS_W(BUS_W)) u_chk (.*);

// File: tb/sim_rt_host_regs.sv
`timescale 1ns/100ps
module sim_rt_host_regs;
  localparam int S_DOUT = 0, S_DOE = 1, S_CHEN = 2, S_PIN = 3, S_SW = 4,
                 S_AHIT = 5, S_BHIT = 6, S_RAM = 7, S_RBL = 8;

  typedef struct {
    int          sel;
    logic [15:0] exp;
    string       tag;
  } item_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1, regSelN = 0, rdWrN = 1, oeN = 1;
  logic [15:0] dataIn = '0;
  logic [4:0] termAddr = 5'h05;
  logic termPar = 1'b1;
  logic cmdValid = 0, cmdIsMode = 0, cmdChanA = 0, cmdStrobeN = 1;
  logic [4:0] cmdAddr = '0, cmdField = '0;
  logic msgErrEvt = 0, errCond = 0, validMsgEvt = 0, termActive = 0;
  logic modeInhibitTf = 0, modeOverrideTf = 0;
  logic [15:0] dataOut, statusWord;
  logic dataOe, ramSel, selfTestEn, selfTestSelA, rbusyLong;
  logic addrHit, bcastHit, msgErrPin;
  logic [1:0] chanEn;

  int tests = 0, fails = 0;
  bit done = 0;
  item_t q[$];

  always #2.5 clk = ~clk;

  rt_host_regs u0 (
    .clk(clk), .rstN(rstN), .csN(csN), .regSelN(regSelN), .rdWrN(rdWrN),
    .oeN(oeN), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe),
    .ramSel(ramSel), .termAddr(termAddr), .termPar(termPar),
    .cmdValid(cmdValid), .cmdAddr(cmdAddr), .cmdField(cmdField),
    .cmdIsMode(cmdIsMode), .cmdChanA(cmdChanA), .cmdStrobeN(cmdStrobeN),
    .msgErrEvt(msgErrEvt), .errCond(errCond), .validMsgEvt(validMsgEvt),
    .termActive(termActive), .modeInhibitTf(modeInhibitTf),
    .modeOverrideTf(modeOverrideTf), .chanEn(chanEn),
    .selfTestEn(selfTestEn), .selfTestSelA(selfTestSelA),
    .rbusyLong(rbusyLong), .addrHit(addrHit), .bcastHit(bcastHit),
    .msgErrPin(msgErrPin), .statusWord(statusWord)
  );

  function automatic logic [15:0] pick(int sel);
    case (sel)
      S_DOUT:  return dataOut;
      S_DOE:   return {15'b0, dataOe};
      S_CHEN:  return {14'b0, chanEn};
      S_PIN:   return {15'b0, msgErrPin};
      S_SW:    return statusWord;
      S_AHIT:  return {15'b0, addrHit};
      S_BHIT:  return {15'b0, bcastHit};
      S_RAM:   return {15'b0, ramSel};
      default: return {15'b0, rbusyLong};
    endcase
  endfunction

  // monitor: compares queued expectations away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it = q.pop_front();
        act = pick(it.sel);
        tests++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, act, it.exp);
        end
      end
    end
  end

  task automatic expect_(int sel, logic [15:0] exp, string tag);
    item_t it;
    it.sel = sel; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic busIdle();
    csN = 1; regSelN = 0; rdWrN = 1; oeN = 1;
  endtask

  task automatic setRead();
    csN = 0; regSelN = 0; rdWrN = 1; oeN = 0;
  endtask

  task automatic writeCtrl(logic [15:0] v);
    csN = 0; regSelN = 0; rdWrN = 0; oeN = 1; dataIn = v;
    tick(); busIdle();
  endtask

  task automatic doReset(logic [4:0] a, logic p);
    rstN = 0; termAddr = a; termPar = p; busIdle();
    repeat (3) tick();
    rstN = 1;
  endtask

  task automatic snap();
    cmdStrobeN = 0; tick(); cmdStrobeN = 1; tick();
  endtask

  task automatic sendCmd(logic [4:0] a, logic [4:0] f, logic mode, logic chA);
    cmdAddr = a; cmdField = f; cmdIsMode = mode; cmdChanA = chA;
    cmdValid = 1; tick(); cmdValid = 0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    // ---------- phase A: good parity, address 5 ----------
    doReset(5'h05, 1'b1);
    setRead();
    expect_(S_DOUT, 16'h07C0, "R1 reset status");
    expect_(S_DOE, 1, "R2 bus driven on read");
    expect_(S_CHEN, 3, "R1 channels enabled");
    expect_(S_RBL, 1, "R1 long lead");
    tick();
    oeN = 1;
    expect_(S_DOE, 0, "R2 released oe high");
    regSelN = 1; oeN = 0;
    expect_(S_DOE, 0, "R2 ram access no drive");
    expect_(S_RAM, 1, "R2 ram select");
    tick(); busIdle();

    cmdAddr = 5'h1F;
    expect_(S_BHIT, 1, "R8 broadcast hit");
    expect_(S_AHIT, 1, "R8 broadcast addr hit");
    tick();
    cmdAddr = 5'h06;
    expect_(S_AHIT, 0, "R8 foreign addr");
    tick();

    writeCtrl(16'h0D92);
    expect_(S_DOUT, 16'h02C0, "R3 control layout");
    expect_(S_CHEN, 2'b10, "R3 only channel B");
    expect_(S_RBL, 0, "R3 short lead");
    tick();
    writeCtrl(16'h0192);
    expect_(S_DOUT, 16'h02C0, "R3 bits 10/11 ignored");
    cmdAddr = 5'h1F;
    expect_(S_BHIT, 0, "R8 broadcast off");
    expect_(S_AHIT, 0, "R8 11111 foreign");
    tick();

    writeCtrl(16'h039F);
    sendCmd(5'h05, 5'h04, 1'b0, 1'b0);
    expect_(S_DOUT, 16'h07A4, "R11 subaddress fields");
    cmdStrobeN = 0; tick(); cmdStrobeN = 1;
    expect_(S_SW, 16'h0000, "R10 no update before rise");
    tick();
    expect_(S_SW, 16'h2B0D, "R10 snapshot layout");
    tick();

    modeInhibitTf = 1; tick(); modeInhibitTf = 0;
    expect_(S_DOUT, 16'h05A4, "R9 tf enabled cleared");
    snap();
    expect_(S_SW, 16'h2B0C, "R9 outgoing tf forced 0");
    modeOverrideTf = 1; tick(); modeOverrideTf = 0;
    expect_(S_DOUT, 16'h07A4, "R9 override restores");
    snap();
    expect_(S_SW, 16'h2B0D, "R9 tf back");

    sendCmd(5'h1F, 5'h04, 1'b0, 1'b1);
    expect_(S_DOUT, 16'h07E4, "R11 channel A bit");
    snap();
    expect_(S_SW, 16'h2B1D, "R10 broadcast received bit");

    validMsgEvt = 1; termActive = 1; tick(); validMsgEvt = 0;
    expect_(S_DOUT, 16'hC7E4, "R11 valid and active");
    tick();
    termActive = 0;
    sendCmd(5'h05, 5'h12, 1'b1, 1'b1);
    expect_(S_DOUT, 16'h07D2, "R11 mode code clears valid");
    tick();

    errCond = 1; msgErrEvt = 1; tick(); msgErrEvt = 0;
    expect_(S_PIN, 1, "R6 pin set");
    expect_(S_DOUT, 16'h27D2, "R7 latch set");
    setRead(); tick(); busIdle();
    expect_(S_DOUT, 16'h27D2, "R7 held while condition present");
    errCond = 0;
    setRead(); msgErrEvt = 1; tick(); busIdle(); msgErrEvt = 0;
    expect_(S_DOUT, 16'h27D2, "R7 set wins over clearing read");
    setRead();
    expect_(S_DOUT, 16'h27D2, "R7 read shows error");
    tick(); busIdle();
    expect_(S_DOUT, 16'h07D2, "R7 cleared after read");
    expect_(S_PIN, 1, "R6 read leaves pin");
    snap();
    expect_(S_SW, 16'h2F0D, "R10 error bit in word");
    cmdAddr = 5'h05; cmdValid = 1; msgErrEvt = 1; tick();
    cmdValid = 0; msgErrEvt = 0;
    expect_(S_PIN, 1, "R6 set wins over command");
    sendCmd(5'h05, 5'h12, 1'b1, 1'b1);
    expect_(S_PIN, 0, "R6 cleared by command");
    tick();

    // ---------- phase B: bad parity ----------
    doReset(5'h04, 1'b1);
    expect_(S_DOUT, 16'h3640, "R5 parity error status");
    expect_(S_PIN, 1, "R5 pin raised");
    expect_(S_CHEN, 0, "R5 channels off");
    tick();
    writeCtrl(16'h1003);
    expect_(S_CHEN, 0, "R5 write cannot enable");
    termAddr = 5'h05; termPar = 1'b1;
    cmdAddr = 5'h04;
    expect_(S_AHIT, 1, "R4 address kept after reset");
    tick();
    cmdAddr = 5'h05;
    expect_(S_AHIT, 0, "R4 new pins ignored");
    expect_(S_DOUT, 16'h3240, "R4 parity bit kept");
    tick();

    // ---------- phase C: address 11111 ----------
    doReset(5'h1F, 1'b0);
    cmdAddr = 5'h1F;
    expect_(S_DOUT, 16'h07C0, "R1 reset status 11111");
    expect_(S_BHIT, 1, "R8 broadcast on");
    tick();
    writeCtrl(16'h100B);
    expect_(S_BHIT, 0, "R8 broadcast disabled");
    expect_(S_AHIT, 1, "R8 11111 as own address");
    tick();
    tick();

    done = 1;
    summary();
    $finish;
  end
endmodule